// File: doc/BRIEF.md
# MMU Fault Capture and Interrupt Unit

This block sits beside the translation logic of an I/O memory management unit and keeps a record of the first translation fault that the unit reports. When a fault is accepted, the block stores several items and then keeps them unchanged for software:

- the faulting page address, packed with the access direction and the page-table layer;
- the faulting physical address;
- the identity of the requester, as a group number and a port number;
- a bit in a per-cause status word.

The block raises an interrupt line whenever a status bit is set and the matching cause is enabled.

Any further faults that arrive while a record is held do not overwrite it. Each one only adds its cause bit to the status word. Software reads the record through a plain 32-bit register port. It then writes a clear bit, which empties the status word and opens the capture registers for the next fault.

The block also keeps the protect physical address that the translation logic uses to redirect faulting accesses. This address is stored in a packed word form and presented on an output. The block also stores a set of secondary enable bits, which it only holds for software.

Fault events arrive on a valid/ready stream. The block never applies back-pressure: `flt_ready` is tied high, and an event is taken in every cycle that `flt_valid` is high. The register port and the interrupt and address outputs are plain signals. Register reads are combinational, have no side effects, and writes take effect at the next clock edge.

Top module: `mmu_fault_trap`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `redir_addr` is zero.
- R2: Reads of any offset other than 0x114, 0x120, 0x124, 0x134, 0x13C, 0x140 and 0x150 return zero. Writes to those other offsets, and writes to the read-only offsets 0x134, 0x13C, 0x140 and 0x150, change no state.
- R3: Offset 0x114 holds the redirect word. A write stores the data with bits 5:0 forced to zero, because the address is aligned to 128 bytes. `redir_addr` (33 bits) equals {word[31], word[30:0], 1'b0}: word bit 31 marks an address above 4 GB, and the rest of the word is the address shifted right by one.
- R4: At offset 0x120, bits 0, 1, 2, 3, 5 and 6 are read/write and all other bits read zero. Writing a one to bit 12 empties the status word and unlocks the capture registers in that cycle. Bit 12 is never stored and always reads zero.
- R5: Offset 0x124 holds the cause enables in bits 6:0, and its upper bits read zero. Cause codes are: 0 translation fault, 1 multi-hit, 2 invalid PA, 3 entry replacement, 4 TLB miss, 5 miss FIFO, 6 prefetch FIFO.
- R6: An event with a cause code from 0 to 6 sets bit <code> of the status word at offset 0x134 at the next edge. An event with cause code 7 has no effect. `flt_ready` is always high.
- R7: The first accepted event while the status word is zero records three values:
  - offset 0x13C becomes {va[31:12], ten zero bits, write at bit 1, layer at bit 0};
  - offset 0x140 becomes the physical address;
  - offset 0x150 holds the group ID in bits 9:7 and the port ID in bits 6:2, with all other bits zero.
- R8: While the status word is non-zero, offsets 0x13C, 0x140 and 0x150 stay frozen, and later events only OR their cause bit into the status word.
- R9: `irq` is high exactly when some status bit and the enable bit at the same position in offset 0x124 are both set. It follows the registered state, so it rises in the cycle after the event is taken.
- R10: If a clear write and a valid event occur in the same cycle, the status word afterwards holds only the new cause bit, and the new event is recorded as a first fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_valid | input | 1 | Fault event valid |
| flt_ready | output | 1 | Fault event ready, always high |
| flt_cause | input | 3 | Cause code, 0 to 6 valid |
| flt_va | input | 32 | Faulting virtual address |
| flt_write | input | 1 | 1 for a write access |
| flt_layer | input | 1 | Page-table layer of the fault |
| flt_pa | input | 32 | Faulting physical address |
| flt_grp | input | 3 | Requester group ID |
| flt_port | input | 5 | Requester port ID |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |
| redir_addr | output | 33 | Redirect physical address |

## Verification
The bench builds the block with its default parameters: seven causes, a 3-bit cause code, a 3-bit group ID, a 5-bit port ID and 128-byte redirect alignment. Because a 3-bit code can also carry the value 7, the ignored-code case can be reached without any wrapper. The requester fields in these parameters fill bits 9:2 of the ID word exactly, so the bench can detect an off-by-one field placement. Random traffic mixes clear writes, events in locked and unlocked states, and same-cycle clear-plus-event cases.

// File: rtl/mft_pkg.sv
package mft_pkg;
  localparam logic [11:0] OFS_REDIR  = 12'h114;
  localparam logic [11:0] OFS_SECCTL = 12'h120;
  localparam logic [11:0] OFS_IRQEN  = 12'h124;
  localparam logic [11:0] OFS_STATUS = 12'h134;
  localparam logic [11:0] OFS_FVA    = 12'h13C;
  localparam logic [11:0] OFS_FPA    = 12'h140;
  localparam logic [11:0] OFS_RQID   = 12'h150;

  localparam logic [31:0] SEC_KEEP_MASK = 32'h0000_006F;
  localparam int          SEC_CLR_BIT   = 12;
  localparam int          ID_PORT_LSB   = 2;
endpackage

// File: rtl/mft_cfg_regs.sv
module mft_cfg_regs
  import mft_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_CAUSE   = 7,
  parameter int ALIGN_BYTES = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          redir_q,
  output logic [31:0]          sec_q,
  output logic [NUM_CAUSE-1:0] en_q,
  output logic                 clr_pulse
);
  localparam int          ZLSB       = $clog2(ALIGN_BYTES) - 1;
  localparam logic [31:0] REDIR_KEEP = ~((32'd1 << ZLSB) - 32'd1);

  logic hit_redir, hit_sec, hit_en;

  assign hit_redir = wr && (addr == ADDR_W'(OFS_REDIR));
  assign hit_sec   = wr && (addr == ADDR_W'(OFS_SECCTL));
  assign hit_en    = wr && (addr == ADDR_W'(OFS_IRQEN));
  assign clr_pulse = hit_sec && wdata[SEC_CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_q <= '0;
      sec_q   <= '0;
      en_q    <= '0;
    end else begin
      if (hit_redir) redir_q <= wdata & REDIR_KEEP;
      if (hit_sec)   sec_q   <= wdata & SEC_KEEP_MASK;
      if (hit_en)    en_q    <= wdata[NUM_CAUSE-1:0];
    end
  end

  a_r3_redir_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    hit_redir |=> (redir_q[ZLSB-1:0] == '0));
endmodule

// File: rtl/mft_capture.sv
module mft_capture
  import mft_pkg::*;
#(
  parameter int NUM_CAUSE = 7,
  parameter int CAUSE_W   = 3,
  parameter int GRP_W     = 3,
  parameter int PORT_W    = 5,
  parameter int PAGE_LSB  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_take,
  input  logic [CAUSE_W-1:0]   ev_cause,
  input  logic [31:0]          ev_va,
  input  logic                 ev_write,
  input  logic                 ev_layer,
  input  logic [31:0]          ev_pa,
  input  logic [GRP_W-1:0]     ev_grp,
  input  logic [PORT_W-1:0]    ev_port,
  input  logic                 clr,
  output logic [NUM_CAUSE-1:0] status_q,
  output logic [31:0]          va_word_q,
  output logic [31:0]          pa_q,
  output logic [31:0]          id_word_q
);
  localparam logic [31:0] PG_MASK = ~((32'd1 << PAGE_LSB) - 32'd1);
  localparam int          GRP_LSB = ID_PORT_LSB + PORT_W;

  logic [NUM_CAUSE-1:0] hit;
  logic                 held;
  logic                 first;

  generate
    for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_cause
      assign hit[i] = ev_take && (ev_cause == CAUSE_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      status_q[i] <= 1'b0;
        else if (clr)    status_q[i] <= hit[i];
        else if (hit[i]) status_q[i] <= 1'b1;
      end
    end
  endgenerate

  assign held  = (|status_q) && !clr;
  assign first = (|hit) && !held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_word_q <= '0;
      pa_q      <= '0;
      id_word_q <= '0;
    end else if (first) begin
      va_word_q <= (ev_va & PG_MASK) | {30'd0, ev_write, ev_layer};
      pa_q      <= ev_pa;
      id_word_q <= (32'(ev_grp) << GRP_LSB) | (32'(ev_port) << ID_PORT_LSB);
    end
  end

  a_r6_accept_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_take && (ev_cause < CAUSE_W'(NUM_CAUSE))) |=> (|status_q));
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ((|status_q) && !clr) |=> ($stable(va_word_q) && $stable(pa_q) && $stable(id_word_q)));
  a_r8_status_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((status_q & $past(status_q)) == $past(status_q)));
  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev_take) |=> (status_q == '0));
endmodule

// File: rtl/mft_readback.sv
module mft_readback
  import mft_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_CAUSE = 7
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          redir_q,
  input  logic [31:0]          sec_q,
  input  logic [NUM_CAUSE-1:0] en_q,
  input  logic [NUM_CAUSE-1:0] status_q,
  input  logic [31:0]          va_word_q,
  input  logic [31:0]          pa_q,
  input  logic [31:0]          id_word_q,
  output logic [31:0]          rdata
);
  always_comb begin
    rdata = '0;
    if      (addr == ADDR_W'(OFS_REDIR))  rdata = redir_q;
    else if (addr == ADDR_W'(OFS_SECCTL)) rdata = sec_q;
    else if (addr == ADDR_W'(OFS_IRQEN))  rdata = 32'(en_q);
    else if (addr == ADDR_W'(OFS_STATUS)) rdata = 32'(status_q);
    else if (addr == ADDR_W'(OFS_FVA))    rdata = va_word_q;
    else if (addr == ADDR_W'(OFS_FPA))    rdata = pa_q;
    else if (addr == ADDR_W'(OFS_RQID))   rdata = id_word_q;
  end
endmodule

// File: rtl/mmu_fault_trap.sv
module mmu_fault_trap #(
  parameter int ADDR_W      = 12,
  parameter int NUM_CAUSE   = 7,
  parameter int CAUSE_W     = $clog2(NUM_CAUSE + 1),
  parameter int GRP_W       = 3,
  parameter int PORT_W      = 5,
  parameter int PAGE_LSB    = 12,
  parameter int ALIGN_BYTES = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flt_valid,
  output logic               flt_ready,
  input  logic [CAUSE_W-1:0] flt_cause,
  input  logic [31:0]        flt_va,
  input  logic               flt_write,
  input  logic               flt_layer,
  input  logic [31:0]        flt_pa,
  input  logic [GRP_W-1:0]   flt_grp,
  input  logic [PORT_W-1:0]  flt_port,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq,
  output logic [32:0]        redir_addr
);
  logic [31:0]          redir_q, sec_q, va_word_q, pa_q, id_word_q;
  logic [NUM_CAUSE-1:0] en_q, status_q;
  logic                 clr_pulse;
  logic                 take;

  assign flt_ready = 1'b1;
  assign take      = flt_valid && flt_ready;

  mft_cfg_regs #(
    .ADDR_W(ADDR_W), .NUM_CAUSE(NUM_CAUSE), .ALIGN_BYTES(ALIGN_BYTES)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .redir_q(redir_q), .sec_q(sec_q), .en_q(en_q), .clr_pulse(clr_pulse)
  );

  mft_capture #(
    .NUM_CAUSE(NUM_CAUSE), .CAUSE_W(CAUSE_W), .GRP_W(GRP_W),
    .PORT_W(PORT_W), .PAGE_LSB(PAGE_LSB)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .ev_take(take), .ev_cause(flt_cause),
    .ev_va(flt_va), .ev_write(flt_write), .ev_layer(flt_layer), .ev_pa(flt_pa),
    .ev_grp(flt_grp), .ev_port(flt_port), .clr(clr_pulse),
    .status_q(status_q), .va_word_q(va_word_q), .pa_q(pa_q), .id_word_q(id_word_q)
  );

  mft_readback #(
    .ADDR_W(ADDR_W), .NUM_CAUSE(NUM_CAUSE)
  ) u_rd (
    .addr(reg_addr), .redir_q(redir_q), .sec_q(sec_q), .en_q(en_q),
    .status_q(status_q), .va_word_q(va_word_q), .pa_q(pa_q),
    .id_word_q(id_word_q), .rdata(reg_rdata)
  );

  assign irq        = |(status_q & en_q);
  assign redir_addr = {redir_q[31], redir_q[30:0], 1'b0};

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
  a_r9_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq);
endmodule

// File: tb/test_mmu_fault_trap.sv
module test_mmu_fault_trap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_valid = 1'b0;
  logic        flt_ready;
  logic [2:0]  flt_cause = '0;
  logic [31:0] flt_va = '0;
  logic        flt_write = 1'b0;
  logic        flt_layer = 1'b0;
  logic [31:0] flt_pa = '0;
  logic [2:0]  flt_grp = '0;
  logic [4:0]  flt_port = '0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [32:0] redir_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  bit [31:0] m_redir = 0, m_sec = 0, m_en = 0, m_st = 0, m_va = 0, m_pa = 0, m_id = 0;

  always #2.5 clk = ~clk;

  mmu_fault_trap i_mmu_fault_trap (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_ready(flt_ready),
    .flt_cause(flt_cause), .flt_va(flt_va), .flt_write(flt_write),
    .flt_layer(flt_layer), .flt_pa(flt_pa), .flt_grp(flt_grp), .flt_port(flt_port),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .redir_addr(redir_addr)
  );

  task automatic chk(input string tag, input string what, input bit [32:0] got, input bit [32:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic bit [31:0] m_read(input bit [11:0] a);
    case (a)
      12'h114: return m_redir;
      12'h120: return m_sec;
      12'h124: return m_en;
      12'h134: return m_st;
      12'h13C: return m_va;
      12'h140: return m_pa;
      12'h150: return m_id;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input bit [11:0] a);
    case (a)
      12'h114: return "R3";
      12'h120: return "R4";
      12'h124: return "R5";
      12'h134: return "R6";
      12'h13C, 12'h140, 12'h150: return "R7";
      default: return "R2";
    endcase
  endfunction

  // behavioural model, updated on every rising edge
  always @(posedge clk) begin
    bit clr;
    bit [31:0] st;
    if (!rst_n) begin
      m_redir = 0; m_sec = 0; m_en = 0; m_st = 0; m_va = 0; m_pa = 0; m_id = 0;
    end else begin
      clr = reg_wr && reg_addr == 12'h120 && reg_wdata[12];
      st = clr ? 32'h0 : m_st;
      if (flt_valid && flt_cause != 3'd7) begin
        if (st == 0) begin
          m_va = {flt_va[31:12], 10'd0, flt_write, flt_layer};
          m_pa = flt_pa;
          m_id = ({29'd0, flt_grp} << 7) | ({27'd0, flt_port} << 2);
        end
        st = st | (32'd1 << flt_cause);
      end
      m_st = st;
      if (reg_wr) begin
        case (reg_addr)
          12'h114: m_redir = reg_wdata & 32'hFFFF_FFC0;
          12'h120: m_sec   = reg_wdata & 32'h0000_006F;
          12'h124: m_en    = reg_wdata & 32'h0000_007F;
          default: ;
        endcase
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag_of(reg_addr), "rdata", {1'b0, reg_rdata}, {1'b0, m_read(reg_addr)});
      chk("R9", "irq", {32'd0, irq}, {32'd0, (m_st & m_en) != 0});
      chk("R3", "redir_addr", redir_addr, {m_redir[31], m_redir[30:0], 1'b0});
      chk("R6", "flt_ready", {32'd0, flt_ready}, 33'd1);
    end
  end

  task automatic drive(input bit w, input bit [11:0] a, input bit [31:0] d,
                       input bit fv, input bit [2:0] c, input bit [31:0] va,
                       input bit fw, input bit fl, input bit [31:0] pa,
                       input bit [2:0] g, input bit [4:0] p);
    @(negedge clk); #1;
    reg_wr = w; reg_addr = a; reg_wdata = d;
    flt_valid = fv; flt_cause = c; flt_va = va; flt_write = fw; flt_layer = fl;
    flt_pa = pa; flt_grp = g; flt_port = p;
  endtask

  task automatic wr_reg(input bit [11:0] a, input bit [31:0] d);
    drive(1, a, d, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fault(input bit [2:0] c, input bit [31:0] va, input bit fw, input bit fl,
                       input bit [31:0] pa, input bit [2:0] g, input bit [4:0] p);
    drive(0, 12'h000, 0, 1, c, va, fw, fl, pa, g, p);
  endtask

  task automatic rd_chk(input string tag, input bit [11:0] a, input bit [31:0] exp);
    drive(0, a, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(tag, "directed read", {1'b0, reg_rdata}, {1'b0, exp});
  endtask

  task automatic irq_chk(input string tag, input bit exp);
    drive(0, 12'h000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(tag, "directed irq", {32'd0, irq}, {32'd0, exp});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "irq after reset", {32'd0, irq}, 33'd0);
    chk("R1", "redir after reset", redir_addr, 33'd0);
    rd_chk("R1", 12'h114, 0); rd_chk("R1", 12'h120, 0); rd_chk("R1", 12'h124, 0);
    rd_chk("R1", 12'h134, 0); rd_chk("R1", 12'h13C, 0); rd_chk("R1", 12'h140, 0);
    rd_chk("R1", 12'h150, 0);
    // R3: redirect word alignment and output form
    wr_reg(12'h114, 32'hFFFF_FFFF);
    rd_chk("R3", 12'h114, 32'hFFFF_FFC0);
    chk("R3", "redir_addr packed", redir_addr, 33'h1_FFFF_FF80);
    // R5 and R4: enable masks, clear bit reads zero
    wr_reg(12'h124, 32'hFFFF_FFFF);
    rd_chk("R5", 12'h124, 32'h0000_007F);
    wr_reg(12'h120, 32'hFFFF_FFFF);
    rd_chk("R4", 12'h120, 32'h0000_006F);
    // R2: read-only and unmapped writes change nothing
    wr_reg(12'h134, 32'hFFFF_FFFF);
    wr_reg(12'h200, 32'hFFFF_FFFF);
    rd_chk("R2", 12'h134, 0);
    rd_chk("R2", 12'h200, 0);
    // R6 / R7: first fault
    fault(3'd2, 32'h1234_5ABC, 1, 1, 32'hCAFE_0000, 3'd5, 5'h13);
    rd_chk("R6", 12'h134, 32'h0000_0004);
    rd_chk("R7", 12'h13C, 32'h1234_5003);
    rd_chk("R7", 12'h140, 32'hCAFE_0000);
    rd_chk("R7", 12'h150, 32'h0000_02CC);
    irq_chk("R9", 1);
    // R8: later fault only ORs status
    fault(3'd4, 32'hAAAA_A000, 0, 0, 32'h1111_1111, 3'd1, 5'h01);
    rd_chk("R8", 12'h134, 32'h0000_0014);
    rd_chk("R8", 12'h13C, 32'h1234_5003);
    rd_chk("R8", 12'h150, 32'h0000_02CC);
    // R6: cause code 7 ignored
    fault(3'd7, 32'h5555_5000, 1, 0, 32'h2222_2222, 3'd2, 5'h02);
    rd_chk("R6", 12'h134, 32'h0000_0014);
    // R9: masking
    wr_reg(12'h124, 32'h0000_0001);
    irq_chk("R9", 0);
    wr_reg(12'h124, 32'h0000_0010);
    irq_chk("R9", 1);
    // R4: clear
    wr_reg(12'h120, 32'h0000_1000);
    rd_chk("R4", 12'h134, 0);
    rd_chk("R4", 12'h120, 0);
    irq_chk("R4", 0);
    rd_chk("R4", 12'h13C, 32'h1234_5003);
    // R10: clear and fault in the same cycle
    fault(3'd0, 32'h0000_1000, 0, 0, 32'h3333_3333, 3'd0, 5'h00);
    drive(1, 12'h120, 32'h0000_1000, 1, 3'd6, 32'h7777_7FFF, 0, 1, 32'h4444_4444, 3'd7, 5'h1F);
    rd_chk("R10", 12'h134, 32'h0000_0040);
    rd_chk("R10", 12'h13C, 32'h7777_7001);
    rd_chk("R10", 12'h150, 32'h0000_03FC);
    // random traffic, compared every cycle against the model
    for (int n = 0; n < 4000; n++) begin
      bit [11:0] alist [9];
      bit [11:0] a;
      bit [31:0] d;
      bit w, fv;
      alist = '{12'h114, 12'h120, 12'h124, 12'h134, 12'h13C, 12'h140, 12'h150, 12'h000, 12'h118};
      a  = alist[$urandom % 9];
      w  = ($urandom % 4) == 0;
      fv = ($urandom % 3) == 0;
      d  = $urandom;
      if (a == 12'h120 && ($urandom % 3) != 0) d[12] = 1'b0;
      drive(w, a, d, fv, 3'($urandom), $urandom, 1'($urandom), 1'($urandom),
            $urandom, 3'($urandom), 5'($urandom));
    end
    drive(0, 12'h000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule